// File: doc/BRIEF.md
# Masked Packed Integer-to-Float Converter

This block is a vector datapath that turns up to sixteen packed signed 32-bit integers into IEEE-754 single-precision values in one pass. The caller picks the vector length for each operation (128, 256 or 512 bits), which sets how many 32-bit lanes take part: 4, 8 or 16. Lane j always lives in bits [32j+31:32j] of both source and destination.

Each lane can be gated by a write-enable bit. A gated-off lane either keeps the old destination value, which the caller supplies on an input, or is cleared to zero. A broadcast option feeds the lowest source lane to every active lane. The rounding mode normally comes from a global control field. A per-operation override replaces it, but only for a full-width operation. A compatibility mode works on four lanes with no gating and passes the destination bits above bit 127 through unchanged. Every other mode clears everything above the active length. The only exception the conversion can raise is inexact, reported as the OR of the lanes that had to round and were written.

The converters are combinational. An optional output register gives a fixed latency of zero or one cycle, and the valid strobe follows the data. Instruction decode, memory access and the register file belong to the surrounding core.

Top module: `pack_i2f_conv`

## Requirements
- R1: Each written lane holds the correctly signed single-precision value of its 32-bit two's-complement input. Zero gives 0x00000000, and integers of magnitude below 2^24 convert exactly.
- R2: When `use_mask` is 1, an active lane with `lane_mask[j]`=0 takes `old_dst` lane j if `zero_masked`=0, or becomes 0 if `zero_masked`=1. When `use_mask` is 0, `lane_mask` has no effect.
- R3: When `bcast` is 1 outside compatibility mode, every active lane converts `src[31:0]` in place of its own lane.
- R4: Rounding encoding: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. Values needing more than 24 significant bits are rounded by the chosen mode.
- R5: The mode comes from `rc_sel` only when `vlen`=10 (512 bits), `rc_ovr`=1 and `compat`=0. In every other case it comes from `ctl_rm`.
- R6: Outside compatibility mode, `vlen` 00/01/10 selects 4/8/16 active lanes (11 behaves as 10), and every destination bit at or above the active length is 0.
- R7: When `compat` is 1, four lanes are converted without gating, broadcast or override, and `dst[511:128]` equals `old_dst[511:128]`.
- R8: `inexact` is 1 exactly when some active, written lane needed rounding. Gated-off lanes never set it.
- R9: A rounding carry-out renormalises the result: 0x7FFFFFFF gives 0x4F000000 under nearest-even. The value -2^31 gives 0xCF000000 exactly.
- R10: With `OUT_REG`=1, results and `out_valid` appear one cycle after `in_valid`, and `out_valid` is low one cycle after `in_valid` is low. After reset, `out_valid`, `dst` and `inexact` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| vlen | input | 2 | Vector length: 00=128, 01=256, 10/11=512 bits |
| compat | input | 1 | Compatibility mode: four lanes, upper destination preserved |
| use_mask | input | 1 | Lane gating enabled |
| lane_mask | input | 16 | Per-lane write enables |
| zero_masked | input | 1 | Gated-off lanes: 1 clear, 0 keep old value |
| bcast | input | 1 | Broadcast lane 0 of the source |
| rc_ovr | input | 1 | Per-operation rounding override request |
| rc_sel | input | 2 | Override rounding mode |
| ctl_rm | input | 2 | Global control rounding field |
| src | input | 512 | Packed signed integers |
| old_dst | input | 512 | Current destination contents |
| out_valid | output | 1 | Result valid |
| dst | output | 512 | Packed float results |
| inexact | output | 1 | Some written lane was rounded |

## Verification
Rounding and lane gating can act on the same operation. A lane whose integer needs rounding may be gated off while the other lanes are written, and the inexact output must then count only the written lanes. The bench builds operations where the only rounding lane is gated off, and others where a gated-off rounding lane sits beside a written rounding lane. It judges `dst` and `inexact` against a lane-by-lane model. Broadcast combined with merging and with the full-width override is also provoked in one operation: the lane-0 value must reach exactly the written lanes under the overriding mode.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_DOWN = 2'b01,
      RM_UP   = 2'b10,
      RM_ZERO = 2'b11
   } rmode_t;

   typedef enum logic [1:0] {
      VL_128 = 2'b00,
      VL_256 = 2'b01,
      VL_512 = 2'b10,
      VL_ALT = 2'b11
   } vlen_t;
endpackage

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
   parameter int W  = 32,
   parameter int CW = $clog2(W) + 1
) (
   input  logic [W-1:0]  val_i,
   output logic [CW-1:0] cnt_o
);
   always_comb begin
      cnt_o = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (val_i[i]) cnt_o = CW'(W - 1 - i);
      end
   end
endmodule

// File: rtl/i2f_lane_cvt.sv
module i2f_lane_cvt
   import i2f_pkg::*;
#(
   parameter int W      = 32,
   parameter int MANT_W = 23,
   parameter int EXP_W  = 8
) (
   input  logic [W-1:0] int_i,
   input  logic [1:0]   rm_i,
   output logic [W-1:0] fp_o,
   output logic         inexact_o
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int CW   = $clog2(W) + 1;
   localparam int GPOS = W - 2 - MANT_W;

   logic              neg;
   logic [W-1:0]      mag;
   logic [CW-1:0]     lz;
   logic [W-1:0]      norm;
   logic              lead;
   logic [MANT_W-1:0] frac;
   logic              guard, sticky, up;
   logic [MANT_W:0]   frac_sum;
   logic [EXP_W-1:0]  exp_v;

   assign neg = int_i[W-1];
   assign mag = neg ? (~int_i + 1'b1) : int_i;

   i2f_lzc #(.W(W), .CW(CW)) u_lzc (.val_i(mag), .cnt_o(lz));

   assign norm   = mag << lz;
   assign lead   = norm[W-1];
   assign frac   = norm[W-2 -: MANT_W];
   assign guard  = norm[GPOS];
   assign sticky = |norm[GPOS-1:0];

   always_comb begin
      case (rmode_t'(rm_i))
         RM_NEAR: up = guard & (sticky | frac[0]);
         RM_DOWN: up = (guard | sticky) & neg;
         RM_UP:   up = (guard | sticky) & ~neg;
         default: up = 1'b0;
      endcase
   end

   assign frac_sum = {1'b0, frac} + {{MANT_W{1'b0}}, up};
   assign exp_v    = EXP_W'(BIAS + W - 1) - EXP_W'(lz) + EXP_W'(frac_sum[MANT_W]);

   always_comb begin
      if (!lead) fp_o = '0;
      else       fp_o = {neg, exp_v, frac_sum[MANT_W-1:0]};
   end

   assign inexact_o = lead & (guard | sticky);
endmodule

// File: rtl/i2f_lane_sel.sv
module i2f_lane_sel #(
   parameter int W = 32
) (
   input  logic         active_i,
   input  logic         enable_i,
   input  logic         zero_i,
   input  logic         keep_i,
   input  logic [W-1:0] conv_i,
   input  logic [W-1:0] old_i,
   input  logic         lane_inx_i,
   output logic [W-1:0] dst_o,
   output logic         inx_o
);
   always_comb begin
      if (active_i) begin
         if (enable_i)    dst_o = conv_i;
         else if (zero_i) dst_o = '0;
         else             dst_o = old_i;
      end else begin
         dst_o = keep_i ? old_i : '0;
      end
   end

   assign inx_o = active_i & enable_i & lane_inx_i;
endmodule

// File: rtl/pack_i2f_conv.sv
module pack_i2f_conv
   import i2f_pkg::*;
#(
   parameter int LANE_W    = 32,
   parameter int MAX_LANES = 16,
   parameter int MANT_W    = 23,
   parameter int EXP_W     = 8,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [1:0]                    vlen,
   input  logic                          compat,
   input  logic                          use_mask,
   input  logic [MAX_LANES-1:0]          lane_mask,
   input  logic                          zero_masked,
   input  logic                          bcast,
   input  logic                          rc_ovr,
   input  logic [1:0]                    rc_sel,
   input  logic [1:0]                    ctl_rm,
   input  logic [LANE_W*MAX_LANES-1:0]   src,
   input  logic [LANE_W*MAX_LANES-1:0]   old_dst,
   output logic                          out_valid,
   output logic [LANE_W*MAX_LANES-1:0]   dst,
   output logic                          inexact
);
   localparam int VEC_W = LANE_W * MAX_LANES;
   localparam int N128  = 128 / LANE_W;
   localparam int N256  = 256 / LANE_W;
   localparam int LCW   = $clog2(MAX_LANES) + 1;

   if (LANE_W != 32) begin : g_bad_lane
      $error("pack_i2f_conv: LANE_W must be 32");
   end
   if (VEC_W != 512) begin : g_bad_vec
      $error("pack_i2f_conv: LANE_W*MAX_LANES must be 512");
   end
   if (LANE_W <= MANT_W + 2) begin : g_bad_mant
      $error("pack_i2f_conv: LANE_W too narrow for MANT_W");
   end

   logic [1:0]           rm_eff;
   logic                 full_w;
   logic                 bcast_eff;
   logic [LCW-1:0]       n_act;
   logic [MAX_LANES-1:0] lane_active;
   logic [MAX_LANES-1:0] lane_en;
   logic [MAX_LANES-1:0] lane_inx_en;
   logic [VEC_W-1:0]     res_dst;
   logic                 res_inexact;

   assign full_w    = vlen[1];
   assign rm_eff    = (!compat && full_w && rc_ovr) ? rc_sel : ctl_rm;
   assign bcast_eff = bcast & ~compat;

   always_comb begin
      if (compat)                      n_act = LCW'(N128);
      else if (vlen_t'(vlen) == VL_128) n_act = LCW'(N128);
      else if (vlen_t'(vlen) == VL_256) n_act = LCW'(N256);
      else                             n_act = LCW'(MAX_LANES);
      for (int j = 0; j < MAX_LANES; j++) begin
         lane_active[j] = (LCW'(j) < n_act);
         lane_en[j]     = compat | ~use_mask | lane_mask[j];
      end
   end

   for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
      localparam int LO = j * LANE_W;
      logic [LANE_W-1:0] lane_in;
      logic [LANE_W-1:0] lane_fp;
      logic              lane_inx;

      assign lane_in = bcast_eff ? src[LANE_W-1:0] : src[LO +: LANE_W];

      i2f_lane_cvt #(.W(LANE_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_cvt (
         .int_i     (lane_in),
         .rm_i      (rm_eff),
         .fp_o      (lane_fp),
         .inexact_o (lane_inx)
      );

      i2f_lane_sel #(.W(LANE_W)) u_sel (
         .active_i   (lane_active[j]),
         .enable_i   (lane_en[j]),
         .zero_i     (zero_masked),
         .keep_i     (compat),
         .conv_i     (lane_fp),
         .old_i      (old_dst[LO +: LANE_W]),
         .lane_inx_i (lane_inx),
         .dst_o      (res_dst[LO +: LANE_W]),
         .inx_o      (lane_inx_en[j])
      );
   end

   assign res_inexact = |lane_inx_en;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            dst       <= '0;
            inexact   <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               dst     <= res_dst;
               inexact <= res_inexact;
            end
         end
      end
   end else begin : g_out_comb
      assign out_valid = in_valid;
      assign dst       = res_dst;
      assign inexact   = res_inexact;
   end
endmodule

// File: rtl/i2f_conv_chk.sv
module i2f_conv_chk #(
   parameter int VEC_W     = 512,
   parameter int MAX_LANES = 16,
   parameter bit OUT_REG   = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [1:0]           vlen,
   input logic                 compat,
   input logic                 use_mask,
   input logic [MAX_LANES-1:0] lane_mask,
   input logic                 zero_masked,
   input logic [VEC_W-1:0]     old_dst,
   input logic [VEC_W-1:0]     res_dst,
   input logic                 res_inexact,
   input logic                 out_valid
);
   p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !compat && vlen == 2'b00) |-> (res_dst[VEC_W-1:128] == '0));

   p_compat_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && compat) |-> (res_dst[VEC_W-1:128] == old_dst[VEC_W-1:128]));

   p_merge_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !compat && use_mask && !zero_masked && lane_mask == '0 && vlen == 2'b00)
      |-> (res_dst == {{(VEC_W-128){1'b0}}, old_dst[127:0]}));

   p_zero_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !compat && use_mask && zero_masked && lane_mask == '0) |-> (res_dst == '0));

   p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !compat && use_mask && lane_mask == '0) |-> !res_inexact);

   if (OUT_REG) begin : g_lat
      p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
   end
endmodule

bind pack_i2f_conv i2f_conv_chk #(
   .VEC_W(VEC_W), .MAX_LANES(MAX_LANES), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vlen(vlen), .compat(compat),
   .use_mask(use_mask), .lane_mask(lane_mask), .zero_masked(zero_masked),
   .old_dst(old_dst), .res_dst(res_dst), .res_inexact(res_inexact),
   .out_valid(out_valid)
);

// File: tb/pack_i2f_conv_bench.sv
module pack_i2f_conv_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   vlen = 2'b00;
   logic         compat = 1'b0;
   logic         use_mask = 1'b0;
   logic [15:0]  lane_mask = '0;
   logic         zero_masked = 1'b0;
   logic         bcast = 1'b0;
   logic         rc_ovr = 1'b0;
   logic [1:0]   rc_sel = 2'b00;
   logic [1:0]   ctl_rm = 2'b00;
   logic [511:0] src = '0;
   logic [511:0] old_dst = '0;
   logic         out_valid;
   logic [511:0] dst;
   logic         inexact;

   int n_chk = 0;
   int n_bad = 0;
   logic [511:0] exp_dst;
   logic         exp_inx;
   logic [31:0]  seed = 32'h1234_5678;

   always #5 clk = ~clk;

   pack_i2f_conv u_pack_i2f_conv (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vlen(vlen), .compat(compat),
      .use_mask(use_mask), .lane_mask(lane_mask), .zero_masked(zero_masked),
      .bcast(bcast), .rc_ovr(rc_ovr), .rc_sel(rc_sel), .ctl_rm(ctl_rm),
      .src(src), .old_dst(old_dst), .out_valid(out_valid), .dst(dst), .inexact(inexact)
   );

   // reference conversion: {inexact, float bits}
   function automatic logic [32:0] ref_cvt(input logic [31:0] x, input logic [1:0] rm);
      logic neg, up;
      logic [63:0] mag, q, rem, half;
      int p, sh;
      neg = x[31];
      mag = neg ? (64'd1 << 32) - {32'd0, x} : {32'd0, x};
      if (mag == 0) return 33'd0;
      p = 0;
      for (int i = 0; i < 33; i++) if (mag[i]) p = i;
      if (p <= 23) begin
         q = mag << (23 - p); rem = 0; half = 1;
      end else begin
         sh = p - 23; q = mag >> sh;
         rem = mag & ((64'd1 << sh) - 1); half = 64'd1 << (sh - 1);
      end
      case (rm)
         2'b00:   up = (rem > half) || (rem == half && q[0]);
         2'b01:   up = (rem != 0) && neg;
         2'b10:   up = (rem != 0) && !neg;
         default: up = 1'b0;
      endcase
      q = q + {63'd0, up};
      if (q == (64'd1 << 24)) begin q = q >> 1; p = p + 1; end
      return {rem != 0, neg, 8'(127 + p), q[22:0]};
   endfunction

   task automatic build_exp();
      int n;
      logic [1:0] rm;
      logic [32:0] r;
      logic [31:0] li;
      n = compat ? 4 : (vlen == 2'b00 ? 4 : (vlen == 2'b01 ? 8 : 16));
      rm = (!compat && vlen[1] && rc_ovr) ? rc_sel : ctl_rm;
      exp_inx = 1'b0;
      for (int j = 0; j < 16; j++) begin
         li = (bcast && !compat) ? src[31:0] : src[j*32 +: 32];
         r = ref_cvt(li, rm);
         if (j >= n)
            exp_dst[j*32 +: 32] = compat ? old_dst[j*32 +: 32] : 32'd0;
         else if (compat || !use_mask || lane_mask[j]) begin
            exp_dst[j*32 +: 32] = r[31:0];
            exp_inx = exp_inx | r[32];
         end else
            exp_dst[j*32 +: 32] = zero_masked ? 32'd0 : old_dst[j*32 +: 32];
      end
   endtask

   task automatic chk1(input string tag, input logic [511:0] act, input logic [511:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, expv);
      end
   endtask

   task automatic defaults();
      vlen = 2'b00; compat = 0; use_mask = 0; lane_mask = '0; zero_masked = 0;
      bcast = 0; rc_ovr = 0; rc_sel = 2'b00; ctl_rm = 2'b00;
   endtask

   // drive current stimulus, check result one cycle later
   task automatic run_vec(input string tag);
      in_valid = 1'b1;
      build_exp();
      @(posedge clk); #1;
      chk1({tag, " valid"}, {511'd0, out_valid}, {511'd0, 1'b1});
      chk1({tag, " dst"}, dst, exp_dst);
      chk1({tag, " inexact"}, {511'd0, inexact}, {511'd0, exp_inx});
      @(negedge clk);
   endtask

   task automatic fill_src(input logic [31:0] base, input logic [31:0] step);
      for (int j = 0; j < 16; j++) src[j*32 +: 32] = base + step * j;
   endtask

   task automatic fill_old();
      for (int j = 0; j < 16; j++) old_dst[j*32 +: 32] = 32'hA5A5_0000 + j;
   endtask

   task automatic t_reset(); // R10
      chk1("R10 reset valid", {511'd0, out_valid}, 512'd0);
      chk1("R10 reset dst", dst, 512'd0);
      chk1("R10 reset inexact", {511'd0, inexact}, 512'd0);
   endtask

   task automatic t_plain(); // R1 R6
      defaults(); fill_old();
      src = '0;
      src[31:0] = 32'd0; src[63:32] = 32'd1; src[95:64] = 32'hFFFF_FFFD; src[127:96] = 32'd16777215;
      for (int j = 4; j < 16; j++) src[j*32 +: 32] = 32'd7;
      run_vec("R1 R6 plain128");
      chk1("R1 lane1 one", {480'd0, dst[63:32]}, {480'd0, 32'h3F80_0000});
      chk1("R1 lane0 zero", {480'd0, dst[31:0]}, 512'd0);
      chk1("R6 upper zero", {128'd0, dst[511:128]}, 512'd0);
      vlen = 2'b01; fill_src(32'hFFFF_FF00, 32'd37);
      run_vec("R1 R6 plain256");
      vlen = 2'b11; run_vec("R6 vlen11 as 512");
   endtask

   task automatic t_round(); // R4 R8
      defaults(); vlen = 2'b10;
      fill_src(32'h0100_0001, 32'h0000_0001);
      src[63:32] = 32'hFEFF_FFFD;
      for (int m = 0; m < 4; m++) begin
         ctl_rm = 2'(m);
         run_vec($sformatf("R4 R8 round mode %0d", m));
      end
   endtask

   task automatic t_override(); // R5
      defaults(); fill_src(32'h0123_4567, 32'h0F0F_0F11);
      vlen = 2'b10; rc_ovr = 1; rc_sel = 2'b11; ctl_rm = 2'b10;
      run_vec("R5 override at 512");
      vlen = 2'b01; run_vec("R5 no override at 256");
      vlen = 2'b10; rc_ovr = 0; run_vec("R5 flag clear uses ctl");
   endtask

   task automatic t_mask(); // R2 R8
      defaults(); fill_old(); vlen = 2'b10;
      fill_src(32'd100, 32'd3);
      src[95:64] = 32'h7FFF_FFF1;           // only rounding lane, masked off
      use_mask = 1; lane_mask = 16'hFFFB; zero_masked = 0;
      run_vec("R2 R8 merge with masked rounding lane");
      zero_masked = 1; lane_mask = 16'h0F0F;
      run_vec("R2 zeroing");
      use_mask = 0; lane_mask = 16'h0000;
      run_vec("R2 mask ignored when off");
      use_mask = 1; lane_mask = 16'h0010; src[159:128] = 32'h0300_0001;
      run_vec("R8 written rounding lane beside masked one");
   endtask

   task automatic t_bcast(); // R3 R5 R2
      defaults(); fill_old(); fill_src(32'h0012_3400, 32'h0111_0000);
      src[31:0] = 32'h8765_4321;
      vlen = 2'b01; bcast = 1;
      run_vec("R3 broadcast 256");
      vlen = 2'b10; rc_ovr = 1; rc_sel = 2'b01; use_mask = 1; lane_mask = 16'hA5C3;
      run_vec("R3 R5 R2 broadcast merge override");
   endtask

   task automatic t_compat(); // R7
      defaults(); fill_old(); fill_src(32'hF000_0001, 32'h0100_0003);
      compat = 1; use_mask = 1; lane_mask = 16'h0000; zero_masked = 1;
      bcast = 1; vlen = 2'b10; rc_ovr = 1; rc_sel = 2'b11; ctl_rm = 2'b10;
      run_vec("R7 compat");
      chk1("R7 upper kept", {128'd0, dst[511:128]}, {128'd0, old_dst[511:128]});
   endtask

   task automatic t_edges(); // R9 R1
      defaults(); vlen = 2'b00; src = '0;
      src[31:0] = 32'h7FFF_FFFF; src[63:32] = 32'h8000_0000;
      src[95:64] = 32'h0100_0001; src[127:96] = 32'hFFFF_FFFF;
      run_vec("R9 edge values");
      chk1("R9 max positive", {480'd0, dst[31:0]}, {480'd0, 32'h4F00_0000});
      chk1("R9 min negative", {480'd0, dst[63:32]}, {480'd0, 32'hCF00_0000});
      chk1("R1 minus one", {480'd0, dst[127:96]}, {480'd0, 32'hBF80_0000});
      ctl_rm = 2'b10; run_vec("R9 carry toward plus");
   endtask

   task automatic t_latency(); // R10
      defaults(); fill_src(32'd5, 32'd1);
      in_valid = 1'b1; @(posedge clk); #1;
      chk1("R10 valid after pulse", {511'd0, out_valid}, {511'd0, 1'b1});
      @(negedge clk); in_valid = 1'b0;
      @(posedge clk); #1;
      chk1("R10 valid drops", {511'd0, out_valid}, 512'd0);
      @(negedge clk);
   endtask

   function automatic logic [31:0] nx(input logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
      return t;
   endfunction

   task automatic t_sweep(); // R1-style mixed sweep covering R2 R3 R4 R5 R6 R7 R8
      for (int k = 0; k < 300; k++) begin
         seed = nx(seed); vlen = seed[1:0]; compat = (seed[7:4] == 4'h0);
         use_mask = seed[8]; zero_masked = seed[9]; bcast = seed[10] & seed[11];
         rc_ovr = seed[12]; rc_sel = seed[14:13]; ctl_rm = seed[16:15];
         lane_mask = seed[31:16];
         for (int j = 0; j < 16; j++) begin
            seed = nx(seed);
            src[j*32 +: 32] = $signed(seed) >>> seed[4:0];
            seed = nx(seed);
            old_dst[j*32 +: 32] = seed;
         end
         run_vec("R8 sweep");
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1; t_reset();
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      t_plain();
      t_round();
      t_override();
      t_mask();
      t_bcast();
      t_compat();
      t_edges();
      t_latency();
      t_sweep();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule